// File: doc/BRIEF.md
# EPROM Bank Read Bridge

This block lets a synchronous on-chip requester read a bank of asynchronous byte-wide EPROMs that share one address bus, one data bus and one output-enable wire, with a separate active-low chip-enable per device. A request gives an address and a bank index. The bridge latches both, pulls low the chip-enable of the chosen device, and later pulls the shared output-enable low. It holds the address constant and samples the data bus once the chip-enable and output-enable access times have both passed. The byte is then returned with a one-cycle valid strobe.

All wait lengths come from speed-grade parameters given in picoseconds: the address/chip-enable access time, the output-enable access time and the output float time. Each is divided by the clock period and rounded up. The chip-enable leads the output-enable by the difference of the two access counts, so output-enable opens as late as the timing allows. After each read, every device is returned to standby and the bridge waits out the float time before it accepts the next request. This keeps a released device from driving the bus while another is turned on.

The controller is one state machine with states IDLE, SELECT, ENABLE and FLOAT. It has four transitions:
- IDLE to SELECT on a request.
- SELECT to ENABLE when the select wait expires.
- ENABLE to FLOAT when the output wait expires, which is also the cycle the data is sampled.
- FLOAT to IDLE when the float wait expires.

Top module: `eprom_read_bridge`

## Requirements
- R1: After reset all chip-enables and the output-enable are high, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken only on a clock edge where `req_ready` is high. `req_ready` is high only in IDLE. A request held while the bridge is busy has no effect until the bridge returns to IDLE.
- R3: At most one chip-enable is low at any time. During a read, bit `req_bank` of `mem_ce_n` (bit 0 = device 0) is the only low bit, and the others stay high (standby).
- R4: `mem_oe_n` is low only while a chip-enable is low. It falls SEL_CYC cycles after the chip-enable falls, where SEL_CYC = ACC_CYC - OE_CYC, and at least 1.
- R5: `mem_addr` equals the accepted address and does not change from the chip-enable falling until it rises again.
- R6: `mem_data` is sampled on the edge that ends the OE_CYC-th cycle with output-enable low. `rsp_valid` is high for exactly one cycle after that edge, with `rsp_data` equal to the sampled byte.
- R7: After a read, all chip-enables and the output-enable stay high for at least FLOAT_CYC cycles before `req_ready` rises or any chip-enable falls again.
- R8: The waits are ACC_CYC = ceil(T_ACC_PS / CLK_PS) and OE_CYC = ceil(T_OE_PS / CLK_PS). With the defaults (8 ns clock, 45/25/25 ns), the chip-enable is low for 6 cycles, the output-enable for 4, and the float wait is 4.
- R9: Each accepted request gives exactly one response, and responses come in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Bridge idle, request taken this edge |
| req_bank | input | BANK_W | Index of the device to read |
| req_addr | input | ADDR_W | Byte address within the device |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_data | output | DATA_W | Byte read |
| mem_addr | output | ADDR_W | Shared address bus to the devices |
| mem_ce_n | output | NUM_DEV | Active-low chip-enable, one per device |
| mem_oe_n | output | 1 | Shared active-low output-enable |
| mem_data | input | DATA_W | Shared data bus from the devices |

## Verification
The assertions take for granted the following about the inputs:
- Reset is asserted before the first read.
- `req_bank` is always below NUM_DEV.
- The real clock period equals CLK_PS, since the wait counts are derived from it.

The bench keeps to these rules: it holds reset for several cycles, uses only banks 0 to 3, and runs the clock at exactly 8 ns. Its EPROM model returns the inverted byte unless the selected device has had its chip-enable, output-enable and address settled for the full access times. Any early sample therefore shows up as a data mismatch.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_ENABLE = 2'd2,
        ST_FLOAT  = 2'd3
    } rd_state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
    parameter int NUM_DEV = 4,
    parameter int BANK_W  = 2
) (
    input  logic [BANK_W-1:0]  bank,
    input  logic               enable,
    output logic [NUM_DEV-1:0] ce_n
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        assign ce_n[g] = !(enable && (bank == BANK_W'(g)));
    end

endmodule

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_read_bridge.sv
module eprom_read_bridge
    import eprom_rd_pkg::*;
#(
    parameter int NUM_DEV    = 4,
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 8,
    parameter int CLK_PS     = 8000,
    parameter int T_ACC_PS   = 45000,
    parameter int T_OE_PS    = 25000,
    parameter int T_FLOAT_PS = 25000
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic [(NUM_DEV>1?$clog2(NUM_DEV):1)-1:0] req_bank,
    input  logic [ADDR_W-1:0]                    req_addr,
    output logic                                 rsp_valid,
    output logic [DATA_W-1:0]                    rsp_data,
    output logic [ADDR_W-1:0]                    mem_addr,
    output logic [NUM_DEV-1:0]                   mem_ce_n,
    output logic                                 mem_oe_n,
    input  logic [DATA_W-1:0]                    mem_data
);

    localparam int BANK_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int ACC_CYC   = at_least_one(ceil_div(T_ACC_PS, CLK_PS));
    localparam int OE_CYC    = at_least_one(ceil_div(T_OE_PS, CLK_PS));
    localparam int FLOAT_CYC = at_least_one(ceil_div(T_FLOAT_PS, CLK_PS));
    localparam int SEL_CYC   = at_least_one(ACC_CYC - OE_CYC);
    localparam int MAX_CYC   = (SEL_CYC > OE_CYC)
                             ? ((SEL_CYC > FLOAT_CYC) ? SEL_CYC : FLOAT_CYC)
                             : ((OE_CYC > FLOAT_CYC) ? OE_CYC : FLOAT_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SEL_LOAD   = CNT_W'(SEL_CYC - 1);
    localparam logic [CNT_W-1:0] OE_LOAD    = CNT_W'(OE_CYC - 1);
    localparam logic [CNT_W-1:0] FLOAT_LOAD = CNT_W'(FLOAT_CYC - 1);

    rd_state_t           state_q, state_d;
    logic                accept;
    logic                t_load;
    logic [CNT_W-1:0]    t_val;
    logic                t_expired;
    logic                sample;
    logic                sel_active;
    logic [BANK_W-1:0]   bank_q, bank_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [NUM_DEV-1:0]  ce_dec_n;
    logic [NUM_DEV-1:0]  ce_n_q;
    logic                oe_n_q;
    logic                rsp_valid_q;
    logic [DATA_W-1:0]   rsp_data_q;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign sample = (state_q == ST_ENABLE) && t_expired;
    assign bank_d = accept ? req_bank : bank_q;
    assign sel_active = (state_d == ST_SELECT) || (state_d == ST_ENABLE);

    eprom_wait_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    eprom_ce_decode #(.NUM_DEV(NUM_DEV), .BANK_W(BANK_W)) u_dec (
        .bank   (bank_d),
        .enable (sel_active),
        .ce_n   (ce_dec_n)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_SELECT;
                    t_load  = 1'b1;
                    t_val   = SEL_LOAD;
                end
            end
            ST_SELECT: begin
                if (t_expired) begin
                    state_d = ST_ENABLE;
                    t_load  = 1'b1;
                    t_val   = OE_LOAD;
                end
            end
            ST_ENABLE: begin
                if (t_expired) begin
                    state_d = ST_FLOAT;
                    t_load  = 1'b1;
                    t_val   = FLOAT_LOAD;
                end
            end
            ST_FLOAT: begin
                if (t_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs, derived from the next state so pins are glitch-free
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_q      <= '1;
            oe_n_q      <= 1'b1;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
            addr_q      <= '0;
            bank_q      <= '0;
        end else begin
            ce_n_q      <= ce_dec_n;
            oe_n_q      <= (state_d != ST_ENABLE);
            rsp_valid_q <= sample;
            if (sample) begin
                rsp_data_q <= mem_data;
            end
            if (accept) begin
                addr_q <= req_addr;
                bank_q <= req_bank;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;
    assign mem_addr  = addr_q;
    assign mem_ce_n  = ce_n_q;
    assign mem_oe_n  = oe_n_q;

endmodule

// File: rtl/eprom_read_chk.sv
module eprom_read_chk #(
    parameter int NUM_DEV   = 4,
    parameter int ADDR_W    = 20,
    parameter int SEL_CYC   = 2,
    parameter int FLOAT_CYC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [NUM_DEV-1:0] mem_ce_n,
    input logic               mem_oe_n
);

    logic        any_ce;
    logic [15:0] ce_low_cnt;
    logic [15:0] gap_cnt;

    assign any_ce = (mem_ce_n != '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_low_cnt <= '0;
            gap_cnt    <= 16'(FLOAT_CYC);
        end else begin
            ce_low_cnt <= any_ce ? ((ce_low_cnt == 16'hFFFF) ? ce_low_cnt : ce_low_cnt + 1'b1) : '0;
            gap_cnt    <= (!any_ce && mem_oe_n)
                        ? ((gap_cnt == 16'hFFFF) ? gap_cnt : gap_cnt + 1'b1) : '0;
        end
    end

    AST_ONE_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_ce_n) <= 1);                                        // R3

    AST_OE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> any_ce);                                              // R4

    AST_OE_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (ce_low_cnt == 16'(SEL_CYC)));                  // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ce && $past(any_ce)) |-> $stable(mem_addr));                   // R5

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!any_ce && mem_oe_n));                               // R2

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                          // R6

    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (any_ce && !$past(any_ce)) |-> (gap_cnt >= 16'(FLOAT_CYC)));        // R7

endmodule

bind eprom_read_bridge eprom_read_chk #(
    .NUM_DEV   (NUM_DEV),
    .ADDR_W    (ADDR_W),
    .SEL_CYC   (SEL_CYC),
    .FLOAT_CYC (FLOAT_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n)
);

// File: tb/tb_eprom_read_bridge.sv
module tb_eprom_read_bridge;

    localparam int NDEV   = 4;
    localparam int AW     = 20;
    localparam int DW     = 8;
    localparam int CLK_PS = 8000;
    localparam int TACC   = 45000;
    localparam int TOE    = 25000;
    localparam int TFLT   = 25000;
    localparam int EXP_ACC = (TACC + CLK_PS - 1) / CLK_PS;   // 6
    localparam int EXP_OE  = (TOE + CLK_PS - 1) / CLK_PS;    // 4
    localparam int EXP_FLT = (TFLT + CLK_PS - 1) / CLK_PS;   // 4
    localparam int EXP_SEL = EXP_ACC - EXP_OE;               // 2

    typedef struct {
        int            bank;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_bank = '0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] mem_addr;
    logic [NDEV-1:0] mem_ce_n;
    logic          mem_oe_n;
    logic [DW-1:0] mem_data;

    int checks = 0;
    int fails  = 0;
    item_t iss_q[$];
    item_t rsp_q[$];

    int ce_age = 0, oe_age = 0, addr_age = 1000, idle_age = 1000;
    int prev_low = 0;
    logic prev_oe = 1'b1, prev_ready = 1'b1;
    logic [AW-1:0] prev_addr = '0;

    always #4 clk = ~clk;

    eprom_read_bridge dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_data(mem_data)
    );

    function automatic logic [DW-1:0] content(input int dev, input logic [AW-1:0] a);
        return a[7:0] ^ a[19:12] ^ 8'(dev * 53 + 17);
    endfunction

    // EPROM bank model: correct byte only after all access times have passed
    always_comb begin
        mem_data = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            if (!mem_ce_n[d] && !mem_oe_n) begin
                if (ce_age * CLK_PS >= TACC && oe_age * CLK_PS >= TOE && addr_age * CLK_PS >= TACC)
                    mem_data = content(d, mem_addr);
                else
                    mem_data = ~content(d, mem_addr);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Driver: presents a request at once, holds it until the bridge takes it
    task automatic issue(input int bank, input logic [AW-1:0] addr, input bit hold);
        item_t it;
        it.bank = bank;
        it.addr = addr;
        it.data = content(bank, addr);
        iss_q.push_back(it);
        rsp_q.push_back(it);
        req_valid = 1'b1;
        req_bank  = 2'(bank);
        req_addr  = addr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (!hold) req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            int lowcnt;
            lowcnt = $countones(~mem_ce_n);
            if (lowcnt > 1) check(0, "R3", "more than one chip-enable low", lowcnt, 1);
            if (!mem_oe_n && lowcnt != 1) check(0, "R4", "oe low without one ce", lowcnt, 1);
            if (lowcnt == 1 && prev_low == 1 && mem_addr != prev_addr)
                check(0, "R5", "address moved during select", mem_addr, prev_addr);
            if (lowcnt == 1 && prev_low == 0) begin
                if (iss_q.size() == 0) begin
                    check(0, "R2", "select with no accepted request", 0, 1);
                end else begin
                    item_t it;
                    it = iss_q.pop_front();
                    check(mem_addr == it.addr, "R5", "mem_addr", mem_addr, it.addr);
                    check(mem_ce_n == ~(NDEV'(1) << it.bank), "R3", "ce decode", mem_ce_n,
                          ~(NDEV'(1) << it.bank));
                end
                check(idle_age >= EXP_FLT, "R7", "idle gap before select", idle_age, EXP_FLT);
            end
            if (!mem_oe_n && prev_oe)
                check(ce_age == EXP_SEL, "R4", "ce lead before oe", ce_age, EXP_SEL);
            if (lowcnt == 0 && prev_low == 1) begin
                check(ce_age == EXP_ACC, "R8", "ce low cycles", ce_age, EXP_ACC);
                check(oe_age == EXP_OE, "R8", "oe low cycles", oe_age, EXP_OE);
            end
            if (req_ready && !prev_ready)
                check(idle_age >= EXP_FLT, "R7", "float wait before ready", idle_age, EXP_FLT);
            if (rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    check(0, "R9", "response with none pending", rsp_data, 0);
                end else begin
                    item_t it;
                    it = rsp_q.pop_front();
                    check(rsp_data == it.data, "R6", "rsp_data", rsp_data, it.data);
                end
            end
            ce_age   = (lowcnt == 1) ? ce_age + 1 : 0;
            oe_age   = (!mem_oe_n) ? oe_age + 1 : 0;
            addr_age = (mem_addr == prev_addr) ? addr_age + 1 : 1;
            idle_age = (lowcnt == 0 && mem_oe_n) ? idle_age + 1 : 0;
            prev_low   = lowcnt;
            prev_oe    = mem_oe_n;
            prev_ready = req_ready;
            prev_addr  = mem_addr;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(0, "R9", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(mem_ce_n == '1, "R1", "ce_n in reset", mem_ce_n, 4'hF);
        check(mem_oe_n == 1'b1, "R1", "oe_n in reset", mem_oe_n, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(mem_ce_n == '1 && mem_oe_n, "R1", "standby after reset", mem_ce_n, 4'hF);

        // single reads to each device (R3, R6)
        for (int b = 0; b < NDEV; b++) begin
            issue(b, 20'h12340 + 20'(b * 7), 1'b0);
            repeat (14) @(negedge clk);
        end
        // address extremes
        issue(0, 20'h00000, 1'b0);
        repeat (14) @(negedge clk);
        issue(3, 20'hFFFFF, 1'b0);
        repeat (14) @(negedge clk);
        // back-to-back stream with valid held while busy (R2, R7, R9)
        issue(1, 20'hABCDE, 1'b1);
        issue(2, 20'h0F0F0, 1'b1);
        issue(1, 20'h55AA5, 1'b1);
        issue(0, 20'h80001, 1'b1);
        issue(3, 20'h3C3C3, 1'b0);
        // irregular pacing
        for (int i = 0; i < 8; i++) begin
            issue(i % NDEV, 20'(i * 20'h1111 + 5), 1'b0);
            repeat (i % 3) @(negedge clk);
        end

        for (int w = 0; w < 200 && rsp_q.size() != 0; w++) @(negedge clk);
        repeat (10) @(negedge clk);
        check(rsp_q.size() == 0, "R9", "responses outstanding", rsp_q.size(), 0);
        check(iss_q.size() == 0, "R2", "accepted but never selected", iss_q.size(), 0);
        check(req_ready && mem_ce_n == '1 && mem_oe_n, "R3", "standby when idle", mem_ce_n, 4'hF);
        summary();
        $finish;
    end

endmodule